// File: doc/BRIEF.md
# Label and SDI Mailbox Receive Filter

This block sits behind an ARINC 429 receiver and decides what happens to each complete 32-bit word. The low ten bits of the word, with the two SDI bits above the eight label bits, form a mailbox index. A match-enable table with one bit per index decides whether the word is kept. A kept word goes into that index's single-entry mailbox, together with a timestamp taken from a free-running counter and an updated status word. The index is also queued in a small notification FIFO. That FIFO carries indices only, never data words.

Host software learns which mailboxes hold fresh data by polling the FIFO count and popping indices. It then reads the status, message, timestamp or match-enable word of any mailbox through a registered read port. It can turn match-enable entries on or off at any time. Reading a message word marks that mailbox as consumed.

Top module: `mbx_rx_filter`

## Requirements
- R1: The mailbox index is word bits [9:8] (SDI) above word bits [7:0] (label), giving 1024 distinct mailboxes. Two words that differ only in SDI land in different mailboxes.
- R2: A word whose index has its match-enable bit clear is dropped. No mailbox changes, and the FIFO count does not move.
- R3: A mailbox keeps one word only. A later accepted word for the same index replaces both the stored message and the stored timestamp.
- R4: The read port returns data one cycle after `rd_en`, with `rd_valid` high in that cycle. `rd_sel` codes are 0 status, 1 message, 2 timestamp, 3 match enable (bit 0). Read data shows the state before any update in the same cycle.
- R5: Status bit 0 is new-data and bit 1 is overwrite; the other bits read zero. A store sets new-data. It also sets overwrite if new-data was already set. A message read (`rd_sel`=1) clears both bits. When a store and a message read hit the same index in one cycle, the result is new-data=1 and overwrite=0.
- R6: The timestamp counter is 0 in the first cycle after reset and increases by one every cycle. An accepted word stores the value the counter has in the cycle the word is presented.
- R7: Every accepted word pushes its index into the FIFO. Pops return indices in arrival order, with `pop_valid` one cycle after `fifo_pop`. `fifo_count` gives the number of queued entries.
- R8: When the FIFO holds `FIFO_DEPTH` entries, an accepted word does not push its index. The sticky `fifo_ovf` flag rises, but the mailbox is still updated. The full test uses the count before any pop in the same cycle.
- R9: A pop while the FIFO is empty does nothing, and `pop_valid` stays low.
- R10: A match-enable write applies from the next cycle. A word presented in the same cycle as the write is judged by the old setting.
- R11: After reset, the FIFO is empty, `fifo_ovf` is low, every match-enable bit is clear and every status word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received word is present this cycle |
| rx_word | input | 32 | Received word |
| cfg_we | input | 1 | Write a match-enable entry |
| cfg_idx | input | 10 | Index of the entry to write |
| cfg_en | input | 1 | Value written to the entry |
| rd_en | input | 1 | Host read request |
| rd_idx | input | 10 | Mailbox index to read |
| rd_sel | input | 2 | Mailbox word select (0 status, 1 message, 2 timestamp, 3 match) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| fifo_pop | input | 1 | Pop one notification index |
| pop_valid | output | 1 | Popped index valid |
| pop_idx | output | 10 | Popped mailbox index |
| fifo_count | output | 5 | Queued notification entries |
| fifo_ovf | output | 1 | Sticky notification overflow |

## Verification
The bench targets the collisions inside a single cycle. These are a match-enable write alongside a word for the same index, a message read alongside a store to the same mailbox, and a pop alongside a push when the FIFO is full or empty. A design that took the new enable early would store a word it should drop. A design that let the read-clear win would lose the new-data flag. A design that tested fullness after the pop would push when it should flag overflow. The bench also sends words that differ only in SDI, to catch an index built from the label alone. It runs the FIFO past its depth to confirm that mailboxes keep updating while pushes are dropped. A long random phase over a small set of indices mixes all of these cases.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MSG    = 2'd1,
    SEL_STAMP  = 2'd2,
    SEL_MATCH  = 2'd3
  } mbx_sel_e;

  localparam int ST_NEW_BIT = 0;
  localparam int ST_OVW_BIT = 1;
endpackage

// File: rtl/mbx_match_table.sv
module mbx_match_table #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic             wval,
  input  logic [IDX_W-1:0] lidx,
  output logic             lhit,
  input  logic [IDX_W-1:0] hidx,
  output logic             hval
);
  localparam int N = 1 << IDX_W;

  logic [N-1:0] tbl;

  always_ff @(posedge clk) begin
    if (rst) tbl <= '0;
    else if (we) tbl[widx] <= wval;
  end

  assign lhit = tbl[lidx];
  assign hval = tbl[hidx];
endmodule

// File: rtl/mbx_sdp_ram.sv
module mbx_sdp_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int N = 1 << AW;

  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbx_idx_fifo.sv
module mbx_idx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 10,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             dout_valid,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             full, empty, push_ok, pop_ok;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
    if (pop_ok) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      count <= '0;
      ovf <= 1'b0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= pop_ok;
      if (push_ok) wptr <= nxt(wptr);
      if (pop_ok) rptr <= nxt(rptr);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
      if (push && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/mbx_rx_filter.sv
module mbx_rx_filter #(
  parameter int SDI_W      = 2,
  parameter int LABEL_W    = 8,
  parameter int WORD_W     = 32,
  parameter int STAMP_W    = 32,
  parameter int FIFO_DEPTH = 16,
  localparam int IDX_W = SDI_W + LABEL_W,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [1:0]        rd_sel,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  input  logic              fifo_pop,
  output logic              pop_valid,
  output logic [IDX_W-1:0]  pop_idx,
  output logic [CNT_W-1:0]  fifo_count,
  output logic              fifo_ovf
);
  import mbx_pkg::*;

  localparam int N = 1 << IDX_W;

  logic [IDX_W-1:0]   rx_idx;
  logic               hit, acc, rd_clr, same_idx, hval;
  logic [STAMP_W-1:0] ts_cnt;
  logic [N-1:0]       st_new, st_ovw;
  logic [WORD_W-1:0]  msg_q;
  logic [STAMP_W-1:0] ts_q;
  logic [1:0]         st_q;
  logic               me_q;
  mbx_sel_e           sel_q;

  // SDI sits directly above the label, so the index is the low field of the word
  assign rx_idx   = rx_word[IDX_W-1:0];
  assign acc      = rx_valid && hit;
  assign rd_clr   = rd_en && (mbx_sel_e'(rd_sel) == SEL_MSG);
  assign same_idx = rd_clr && (rd_idx == rx_idx);

  always_ff @(posedge clk) begin
    if (rst) ts_cnt <= '0;
    else ts_cnt <= ts_cnt + 1'b1;
  end

  mbx_match_table #(.IDX_W(IDX_W)) u_match (
    .clk(clk), .rst(rst),
    .we(cfg_we), .widx(cfg_idx), .wval(cfg_en),
    .lidx(rx_idx), .lhit(hit),
    .hidx(rd_idx), .hval(hval)
  );

  mbx_sdp_ram #(.AW(IDX_W), .DW(WORD_W)) u_msg_ram (
    .clk(clk), .we(acc), .waddr(rx_idx), .wdata(rx_word),
    .raddr(rd_idx), .rdata(msg_q)
  );

  mbx_sdp_ram #(.AW(IDX_W), .DW(STAMP_W)) u_ts_ram (
    .clk(clk), .we(acc), .waddr(rx_idx), .wdata(ts_cnt),
    .raddr(rd_idx), .rdata(ts_q)
  );

  mbx_idx_fifo #(.DEPTH(FIFO_DEPTH), .W(IDX_W)) u_fifo (
    .clk(clk), .rst(rst),
    .push(acc), .din(rx_idx), .pop(fifo_pop),
    .dout(pop_idx), .dout_valid(pop_valid),
    .count(fifo_count), .ovf(fifo_ovf)
  );

  // Status flags: a message read clears, a store in the same cycle wins
  always_ff @(posedge clk) begin
    if (rst) begin
      st_new <= '0;
      st_ovw <= '0;
    end else begin
      if (rd_clr) begin
        st_new[rd_idx] <= 1'b0;
        st_ovw[rd_idx] <= 1'b0;
      end
      if (acc) begin
        st_new[rx_idx] <= 1'b1;
        st_ovw[rx_idx] <= same_idx ? 1'b0 : (st_ovw[rx_idx] | st_new[rx_idx]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else rd_valid <= rd_en;
    sel_q <= mbx_sel_e'(rd_sel);
    st_q[ST_NEW_BIT] <= st_new[rd_idx];
    st_q[ST_OVW_BIT] <= st_ovw[rd_idx];
    me_q <= hval;
  end

  always_comb begin
    unique case (sel_q)
      SEL_STATUS: rd_data = WORD_W'(st_q);
      SEL_MSG:    rd_data = msg_q;
      SEL_STAMP:  rd_data = WORD_W'(ts_q);
      default:    rd_data = WORD_W'(me_q);
    endcase
  end
endmodule

// File: rtl/mbx_rx_filter_chk.sv
module mbx_rx_filter_chk #(
  parameter int STAMP_W    = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int CNT_W      = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               acc,
  input logic               fifo_pop,
  input logic               pop_valid,
  input logic [CNT_W-1:0]   fifo_count,
  input logic               fifo_ovf,
  input logic [STAMP_W-1:0] ts_cnt,
  input logic               rd_en,
  input logic               rd_valid
);
  p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CNT_W'(FIFO_DEPTH));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_ovf |=> fifo_ovf);

  p_full_sets_ovf_r8: assert property (@(posedge clk) disable iff (rst)
    (acc && fifo_count == CNT_W'(FIFO_DEPTH)) |=> fifo_ovf);

  p_full_no_grow_r8: assert property (@(posedge clk) disable iff (rst)
    (acc && !fifo_pop && fifo_count == CNT_W'(FIFO_DEPTH)) |=> fifo_count == CNT_W'(FIFO_DEPTH));

  p_push_grows_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && !fifo_pop && fifo_count != CNT_W'(FIFO_DEPTH)) |=> fifo_count == $past(fifo_count) + 1'b1);

  p_reject_still_r2: assert property (@(posedge clk) disable iff (rst)
    (!acc && !fifo_pop) |=> $stable(fifo_count));

  p_empty_pop_r9: assert property (@(posedge clk) disable iff (rst)
    (fifo_pop && fifo_count == '0) |=> !pop_valid);

  p_stamp_step_r6: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ts_cnt == $past(ts_cnt) + 1'b1);

  p_rd_latency_r4: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

bind mbx_rx_filter mbx_rx_filter_chk #(
  .STAMP_W(STAMP_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .acc(acc), .fifo_pop(fifo_pop),
  .pop_valid(pop_valid), .fifo_count(fifo_count), .fifo_ovf(fifo_ovf),
  .ts_cnt(ts_cnt), .rd_en(rd_en), .rd_valid(rd_valid)
);

// File: tb/test_mbx_rx_filter.sv
module test_mbx_rx_filter;
  localparam int DEPTH = 16;
  localparam int NMBX  = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 0, cfg_we = 0, cfg_en = 0, rd_en = 0, fifo_pop = 0;
  logic [31:0] rx_word = '0;
  logic [9:0]  cfg_idx = '0, rd_idx = '0;
  logic [1:0]  rd_sel = '0;
  logic        rd_valid, pop_valid, fifo_ovf;
  logic [31:0] rd_data;
  logic [9:0]  pop_idx;
  logic [4:0]  fifo_count;

  int compared = 0, mismatched = 0;
  string cur_req = "R11";
  bit done = 0;

  always #4 clk = ~clk;

  mbx_rx_filter #(.FIFO_DEPTH(DEPTH)) i_mbx_rx_filter (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_word(rx_word),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_sel(rd_sel),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .fifo_pop(fifo_pop), .pop_valid(pop_valid), .pop_idx(pop_idx),
    .fifo_count(fifo_count), .fifo_ovf(fifo_ovf)
  );

  // Behavioural reference
  bit        m_match [NMBX];
  bit        m_new   [NMBX];
  bit        m_ovw   [NMBX];
  bit        m_wr    [NMBX];
  bit [31:0] m_msg   [NMBX];
  bit [31:0] m_stamp [NMBX];
  int        q[$];
  bit        m_ovf;
  bit [31:0] m_ts;
  bit        e_rd_valid, e_rd_known, e_pop_valid;
  bit [31:0] e_rd_data;
  bit [9:0]  e_pop_idx;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NMBX; i++) begin
        m_match[i] = 0; m_new[i] = 0; m_ovw[i] = 0;
      end
      q.delete();
      m_ovf = 0; m_ts = 0; e_rd_valid = 0; e_pop_valid = 0;
    end else begin
      int  ix, ri;
      bit  full;
      ix = int'(rx_word[9:0]);
      ri = int'(rd_idx);
      e_rd_valid = rd_en;
      e_rd_known = 1;
      if (rd_en) begin
        case (rd_sel)
          2'd0: e_rd_data = {30'd0, m_ovw[ri], m_new[ri]};
          2'd1: begin e_rd_data = m_msg[ri];   e_rd_known = m_wr[ri]; end
          2'd2: begin e_rd_data = m_stamp[ri]; e_rd_known = m_wr[ri]; end
          default: e_rd_data = {31'd0, m_match[ri]};
        endcase
      end
      full = (q.size() == DEPTH);
      e_pop_valid = 0;
      if (fifo_pop && q.size() > 0) begin
        e_pop_valid = 1;
        e_pop_idx = 10'(q.pop_front());
      end
      if (rd_en && rd_sel == 2'd1) begin m_new[ri] = 0; m_ovw[ri] = 0; end
      if (rx_valid && m_match[ix]) begin
        m_ovw[ix] = m_ovw[ix] | m_new[ix];
        m_new[ix] = 1;
        m_msg[ix] = rx_word;
        m_stamp[ix] = m_ts;
        m_wr[ix] = 1;
        if (full) m_ovf = 1; else q.push_back(ix);
      end
      if (cfg_we) m_match[cfg_idx] = cfg_en;
      m_ts = m_ts + 1;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("R11", "fifo_count", 32'(fifo_count), 32'(q.size()));
      check("R8", "fifo_ovf", 32'(fifo_ovf), 32'(m_ovf));
      check("R4", "rd_valid", 32'(rd_valid), 32'(e_rd_valid));
      check("R9", "pop_valid", 32'(pop_valid), 32'(e_pop_valid));
      if (e_pop_valid) check("R7", "pop_idx", 32'(pop_idx), 32'(e_pop_idx));
      if (e_rd_valid && e_rd_known) check(cur_req, "rd_data", rd_data, e_rd_data);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_in();
    rx_valid = 0; cfg_we = 0; rd_en = 0; fifo_pop = 0;
  endtask

  task automatic set_match(int idx, bit en);
    cfg_we = 1; cfg_idx = 10'(idx); cfg_en = en;
    @(negedge clk); clear_in();
  endtask

  task automatic send(logic [31:0] w);
    rx_valid = 1; rx_word = w;
    @(negedge clk); clear_in();
  endtask

  task automatic rd(int idx, int sel);
    rd_en = 1; rd_idx = 10'(idx); rd_sel = 2'(sel);
    @(negedge clk); clear_in();
  endtask

  task automatic pop();
    fifo_pop = 1;
    @(negedge clk); clear_in();
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 0;
    // R11: reset state visible through the read port
    cur_req = "R11";
    rd(5, 0); rd(5, 3); rd(10'h3FF, 0); idle(1);

    // R1: SDI distinguishes mailboxes sharing a label
    cur_req = "R1";
    set_match(10'h005, 1); set_match(10'h105, 1); set_match(10'h3FF, 1);
    send(32'hAAAA_0005); send(32'hBBBB_0105); send(32'h1234_57FF);
    rd(10'h005, 1); rd(10'h105, 1); rd(10'h3FF, 1);

    // R2: word for a disabled index dropped
    cur_req = "R2";
    send(32'hDEAD_0205); rd(10'h205, 0); idle(1);

    // R6: stamps
    cur_req = "R6";
    rd(10'h005, 2); rd(10'h105, 2); rd(10'h3FF, 2);

    // R3 and R5: overwrite without reading
    cur_req = "R3";
    send(32'hCAFE_0105); send(32'hF00D_0105); rd(10'h105, 1); rd(10'h105, 2);
    cur_req = "R5";
    rd(10'h105, 0); send(32'h0000_1105); send(32'h0000_2105);
    rd(10'h105, 0); rd(10'h105, 1); rd(10'h105, 0);
    // R5: store and message read on the same index in one cycle
    send(32'h0BAD_0005); rx_valid = 1; rx_word = 32'h5555_0005;
    rd_en = 1; rd_idx = 10'h005; rd_sel = 2'd1;
    @(negedge clk); clear_in();
    rd(10'h005, 0); rd(10'h005, 1);

    // R7: pop order, then R9 pop on empty
    cur_req = "R7";
    repeat (14) pop();
    cur_req = "R9";
    pop(); pop(); idle(1);

    // R10: disable in same cycle as a word is still accepted, next is dropped
    cur_req = "R10";
    cfg_we = 1; cfg_idx = 10'h3FF; cfg_en = 0; rx_valid = 1; rx_word = 32'h7777_03FF;
    @(negedge clk); clear_in();
    send(32'h8888_03FF); rd(10'h3FF, 1); rd(10'h3FF, 3);
    cfg_we = 1; cfg_idx = 10'h0A1; cfg_en = 1; rx_valid = 1; rx_word = 32'h1111_00A1;
    @(negedge clk); clear_in();
    send(32'h2222_00A1); rd(10'h0A1, 1);

    // R8: overflow while mailboxes keep updating; pop and push at full
    cur_req = "R8";
    for (int i = 0; i < DEPTH + 3; i++) send(32'h4000_0000 | 32'(i << 12) | 32'h005);
    rd(10'h005, 1); rd(10'h005, 0);
    rx_valid = 1; rx_word = 32'h9999_0105; fifo_pop = 1;
    @(negedge clk); clear_in();
    rd(10'h105, 1);
    repeat (DEPTH + 2) pop();

    // Mixed random traffic
    cur_req = "R4";
    rst = 1; idle(2); rst = 0;
    for (int c = 0; c < 600; c++) begin
      int lab;
      lab = ($urandom % 3) * 37;
      cfg_we   = ($urandom % 8) == 0;
      cfg_idx  = 10'({2'($urandom), 8'(lab)});
      cfg_en   = ($urandom % 4) != 0;
      rx_valid = ($urandom % 2) == 0;
      rx_word  = {22'($urandom), 2'($urandom), 8'(($urandom % 3) * 37)};
      rd_en    = ($urandom % 2) == 0;
      rd_idx   = 10'({2'($urandom), 8'(($urandom % 3) * 37)});
      rd_sel   = 2'($urandom);
      fifo_pop = ($urandom % 3) == 0;
      @(negedge clk);
    end
    clear_in(); idle(2);
    finish_run();
  end
endmodule